// File: doc/BRIEF.md
# Segment Access-Control Checker

This block judges every memory reference that passes through a segmented address-translation unit. A request carries a 16-bit virtual address, a privilege mode, a select between instruction and data space, and a read/write flag. The top three address bits pick one of eight segment descriptors. Each privilege mode and space pair has its own set of eight. Each descriptor holds a relocation base, a 3-bit protection code and two sticky status flags. The protection code and the direction of the access decide whether the reference goes ahead, goes ahead with a management trap, or is aborted. An abort is reported either as a missing (non-resident) segment or as a read-only violation.

For references that are not aborted, the block forms the physical address from the base and the in-segment offset. It flags the reference when that address lands in the I/O page, and it updates the descriptor's written and accessed flags. One input selects between the narrow physical space and the wide physical space, which has four more address bits. The I/O page is always the top 8 KiB of whichever space is selected. Descriptors are loaded through a configuration write port. Their status flags can be read back through a separate index port.

Top module: `segAccessCheck`

## Requirements
- R1: The descriptor used is chosen by address bits 15:13 together with the request's mode and space. Each of the six legal (mode, space) pairs owns eight independent descriptors.
- R2: Mode code 0 is kernel, 1 is supervisor and 3 is user. A request with mode code 2 gives a non-resident abort whatever the descriptors hold. A configuration write with mode code 2 changes nothing.
- R3: Protection codes 0, 3 and 7 give a non-resident abort for reads and for writes. At most one of the three outcome flags (non-resident abort, read-only abort, trap) is ever set.
- R4: Code 1 traps a read and gives a read-only abort on a write. Code 2 allows a read plainly and gives a read-only abort on a write. A read never produces a read-only abort.
- R5: Code 4 traps every access. Code 5 traps writes only and allows reads plainly. Code 6 allows every access with no trap.
- R6: rdStatus bit 0 (written) is set by every write that is not aborted. rdStatus bit 1 (accessed) is set only by an access that raises a trap. Both flags are sticky, and a configuration write to the descriptor clears them.
- R7: An aborted request leaves both status flags unchanged and keeps rspAccess low.
- R8: rspPhys equals base times 64 plus address bits 12:0, truncated to the physical width. With addr22En low, the result is further cut to the narrow width (4 bits fewer).
- R9: rspIoPage is high exactly when an allowed access has a physical address at or above the top-8-KiB boundary of the selected space. That boundary is 0x3E000 in the narrow space and 0x3FE000 in the wide space.
- R10: Each result appears exactly one clock cycle after its request is sampled. rspValid is high for exactly that one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Descriptor load strobe |
| cfgMode | input | 2 | Mode of the descriptor being loaded |
| cfgSpace | input | 1 | Space of the descriptor being loaded (1 = data) |
| cfgSeg | input | 3 | Segment number of the descriptor being loaded |
| cfgBase | input | 16 | Relocation base, in 64-byte blocks |
| cfgAcf | input | 3 | Protection code |
| addr22En | input | 1 | Select the wide physical space |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | 16 | Virtual address |
| reqMode | input | 2 | Privilege mode of the request |
| reqSpace | input | 1 | Space of the request (1 = data) |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| rspValid | output | 1 | Result strobe |
| rspAccess | output | 1 | Access may proceed (not aborted) |
| rspAbortNr | output | 1 | Non-resident abort |
| rspAbortRo | output | 1 | Read-only abort |
| rspTrap | output | 1 | Management trap raised |
| rspPhys | output | 22 | Physical address |
| rspIoPage | output | 1 | Physical address lies in the I/O page |
| rdMode | input | 2 | Status readback mode |
| rdSpace | input | 1 | Status readback space |
| rdSeg | input | 3 | Status readback segment |
| rdStatus | output | 2 | Bit 1 accessed, bit 0 written |

## Verification
The bench builds the block with its default parameters: a 16-bit virtual address, 3 segment bits, a 16-bit base and a 22-bit physical width with 4 extension bits. These values put both I/O page thresholds inside the range of base and offset combinations the bench can drive. The narrow-space truncation and the wide-space boundary can therefore both be tested one address below and at the limit. The same build walks every protection code in both directions and keeps descriptors of different mode and space pairs apart.

// File: rtl/segChkPkg.sv
package segChkPkg;

  typedef enum logic [1:0] {
    OUT_ALLOW    = 2'd0,
    OUT_TRAP     = 2'd1,
    OUT_ABORT_NR = 2'd2,
    OUT_ABORT_RO = 2'd3
  } outcomeE;

  typedef struct packed {
    logic capture;
    logic accessOk;
    logic setWritten;
    logic setAccessed;
  } ctrlStrobeT;

  function automatic logic modeOk(input logic [1:0] m);
    return m != 2'd2;
  endfunction

  function automatic logic [1:0] modeSlot(input logic [1:0] m);
    return (m == 2'd3) ? 2'd2 : m;
  endfunction

  function automatic outcomeE decodeAcf(input logic [2:0] acf, input logic isWr);
    outcomeE r;
    case (acf)
      3'd1:    r = isWr ? OUT_ABORT_RO : OUT_TRAP;
      3'd2:    r = isWr ? OUT_ABORT_RO : OUT_ALLOW;
      3'd4:    r = OUT_TRAP;
      3'd5:    r = isWr ? OUT_TRAP : OUT_ALLOW;
      3'd6:    r = OUT_ALLOW;
      default: r = OUT_ABORT_NR;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segChkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       modeLegal,
  input  logic [2:0] acf,
  output ctrlStrobeT strobes,
  output logic       rspValid,
  output logic       rspAccess,
  output logic       rspAbortNr,
  output logic       rspAbortRo,
  output logic       rspTrap
);

  outcomeE outcome;
  logic    isAbort;

  always_comb begin
    outcome = modeLegal ? decodeAcf(acf, reqWrite) : OUT_ABORT_NR;
    isAbort = (outcome == OUT_ABORT_NR) || (outcome == OUT_ABORT_RO);
    strobes.capture     = reqValid;
    strobes.accessOk    = reqValid && !isAbort;
    strobes.setWritten  = reqValid && !isAbort && reqWrite;
    strobes.setAccessed = reqValid && (outcome == OUT_TRAP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspAccess  <= 1'b0;
      rspAbortNr <= 1'b0;
      rspAbortRo <= 1'b0;
      rspTrap    <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspAccess  <= strobes.accessOk;
      rspAbortNr <= reqValid && (outcome == OUT_ABORT_NR);
      rspAbortRo <= reqValid && (outcome == OUT_ABORT_RO);
      rspTrap    <= reqValid && (outcome == OUT_TRAP);
    end
  end

endmodule

// File: rtl/segData.sv
module segData
  import segChkPkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_W     = 3,
  parameter int BASE_W    = 16,
  parameter int BLK_SHIFT = 6,
  parameter int PHYS_W    = 22,
  parameter int EXT_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgSpace,
  input  logic [SEG_W-1:0]  cfgSeg,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [2:0]        cfgAcf,
  input  logic              addr22En,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [1:0]        reqMode,
  input  logic              reqSpace,
  input  ctrlStrobeT        strobes,
  input  logic [1:0]        rdMode,
  input  logic              rdSpace,
  input  logic [SEG_W-1:0]  rdSeg,
  output logic              modeLegal,
  output logic [2:0]        acf,
  output logic [PHYS_W-1:0] rspPhys,
  output logic              rspIoPage,
  output logic [1:0]        rdStatus
);

  localparam int OFF_W   = VA_W - SEG_W;
  localparam int SEGS    = 1 << SEG_W;
  localparam int ENTRIES = 3 * 2 * SEGS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int SUM_W   = (BASE_W + BLK_SHIFT > OFF_W) ? BASE_W + BLK_SHIFT + 1 : OFF_W + 1;
  localparam logic [PHYS_W-1:0] ALL_ONES    = {PHYS_W{1'b1}};
  localparam logic [PHYS_W-1:0] NARROW_MASK = ALL_ONES >> EXT_BITS;
  localparam logic [PHYS_W-1:0] IO_WIDE     = ALL_ONES << OFF_W;
  localparam logic [PHYS_W-1:0] IO_NARROW   = IO_WIDE & NARROW_MASK;

  logic [BASE_W-1:0] baseQ [ENTRIES];
  logic [2:0]        acfQ  [ENTRIES];
  logic              accQ  [ENTRIES];
  logic              wrQ   [ENTRIES];

  function automatic logic [IDX_W-1:0] entryIdx(input logic [1:0] m, input logic s,
                                                input logic [SEG_W-1:0] g);
    return IDX_W'({modeSlot(m), s, g});
  endfunction

  logic [IDX_W-1:0]  reqIdx, cfgIdx, rdIdx;
  logic [SEG_W-1:0]  reqSeg;
  logic [OFF_W-1:0]  reqOff;
  logic [SUM_W-1:0]  sumFull;
  logic [PHYS_W-1:0] physWide, physSel, ioBase;

  assign reqSeg    = reqAddr[VA_W-1 -: SEG_W];
  assign reqOff    = reqAddr[OFF_W-1:0];
  assign reqIdx    = entryIdx(reqMode, reqSpace, reqSeg);
  assign cfgIdx    = entryIdx(cfgMode, cfgSpace, cfgSeg);
  assign rdIdx     = entryIdx(rdMode, rdSpace, rdSeg);
  assign modeLegal = modeOk(reqMode);
  assign acf       = modeLegal ? acfQ[reqIdx] : 3'd0;
  assign rdStatus  = modeOk(rdMode) ? {accQ[rdIdx], wrQ[rdIdx]} : 2'b00;

  assign sumFull  = (SUM_W'(baseQ[reqIdx]) << BLK_SHIFT) + SUM_W'(reqOff);
  assign physWide = sumFull[PHYS_W-1:0];

  generate
    if (EXT_BITS > 0) begin : g_narrowMode
      assign physSel = addr22En ? physWide : (physWide & NARROW_MASK);
      assign ioBase  = addr22En ? IO_WIDE : IO_NARROW;
    end else begin : g_wideOnly
      assign physSel = physWide;
      assign ioBase  = IO_WIDE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        baseQ[i] <= '0;
        acfQ[i]  <= 3'd0;
        accQ[i]  <= 1'b0;
        wrQ[i]   <= 1'b0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (cfgWe && modeOk(cfgMode) && cfgIdx == IDX_W'(i)) begin
          baseQ[i] <= cfgBase;
          acfQ[i]  <= cfgAcf;
          accQ[i]  <= 1'b0;
          wrQ[i]   <= 1'b0;
        end else if (strobes.capture && modeLegal && reqIdx == IDX_W'(i)) begin
          accQ[i] <= accQ[i] | strobes.setAccessed;
          wrQ[i]  <= wrQ[i] | strobes.setWritten;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPhys   <= '0;
      rspIoPage <= 1'b0;
    end else if (strobes.capture) begin
      rspPhys   <= physSel;
      rspIoPage <= strobes.accessOk && (physSel >= ioBase);
    end else begin
      rspIoPage <= 1'b0;
    end
  end

endmodule

// File: rtl/segAccessCheck.sv
module segAccessCheck
  import segChkPkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_W     = 3,
  parameter int BASE_W    = 16,
  parameter int BLK_SHIFT = 6,
  parameter int PHYS_W    = 22,
  parameter int EXT_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgSpace,
  input  logic [SEG_W-1:0]  cfgSeg,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [2:0]        cfgAcf,
  input  logic              addr22En,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [1:0]        reqMode,
  input  logic              reqSpace,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspAccess,
  output logic              rspAbortNr,
  output logic              rspAbortRo,
  output logic              rspTrap,
  output logic [PHYS_W-1:0] rspPhys,
  output logic              rspIoPage,
  input  logic [1:0]        rdMode,
  input  logic              rdSpace,
  input  logic [SEG_W-1:0]  rdSeg,
  output logic [1:0]        rdStatus
);

  ctrlStrobeT strobes;
  logic       modeLegal;
  logic [2:0] acf;

  segCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .modeLegal(modeLegal), .acf(acf), .strobes(strobes),
    .rspValid(rspValid), .rspAccess(rspAccess), .rspAbortNr(rspAbortNr),
    .rspAbortRo(rspAbortRo), .rspTrap(rspTrap)
  );

  segData #(
    .VA_W(VA_W), .SEG_W(SEG_W), .BASE_W(BASE_W), .BLK_SHIFT(BLK_SHIFT),
    .PHYS_W(PHYS_W), .EXT_BITS(EXT_BITS)
  ) u_data (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgSpace(cfgSpace),
    .cfgSeg(cfgSeg), .cfgBase(cfgBase), .cfgAcf(cfgAcf), .addr22En(addr22En),
    .reqAddr(reqAddr), .reqMode(reqMode), .reqSpace(reqSpace), .strobes(strobes),
    .rdMode(rdMode), .rdSpace(rdSpace), .rdSeg(rdSeg), .modeLegal(modeLegal),
    .acf(acf), .rspPhys(rspPhys), .rspIoPage(rspIoPage), .rdStatus(rdStatus)
  );

endmodule

// File: rtl/segAccessCheckSva.sv
module segAccessCheckSva (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqMode,
  input logic       reqWrite,
  input logic       rspValid,
  input logic       rspAccess,
  input logic       rspAbortNr,
  input logic       rspAbortRo,
  input logic       rspTrap,
  input logic       rspIoPage
);

  assert_mode2_abort_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqMode == 2'd2 |=> rspAbortNr && !rspAccess);

  assert_outcome_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspAbortNr, rspAbortRo, rspTrap}));

  assert_read_never_ro_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> !rspAbortRo);

  assert_io_needs_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspIoPage |-> rspAccess);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && !rspAccess);

endmodule

bind segAccessCheck segAccessCheckSva u_sva (.*);

// File: tb/segAccessCheck_bench.sv
module segAccessCheck_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgMode = '0;
  logic        cfgSpace = 1'b0;
  logic [2:0]  cfgSeg = '0;
  logic [15:0] cfgBase = '0;
  logic [2:0]  cfgAcf = '0;
  logic        addr22En = 1'b1;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqMode = '0;
  logic        reqSpace = 1'b0;
  logic        reqWrite = 1'b0;
  logic        rspValid, rspAccess, rspAbortNr, rspAbortRo, rspTrap, rspIoPage;
  logic [21:0] rspPhys;
  logic [1:0]  rdMode = '0;
  logic        rdSpace = 1'b0;
  logic [2:0]  rdSeg = '0;
  logic [1:0]  rdStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  segAccessCheck u_segAccessCheck (.*);

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadDesc(input logic [1:0] m, input logic s, input logic [2:0] g,
                          input logic [15:0] b, input logic [2:0] a);
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = m; cfgSpace = s; cfgSeg = g; cfgBase = b; cfgAcf = a;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic access(input logic [1:0] m, input logic s, input logic [15:0] va,
                        input logic w);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqSpace = s; reqAddr = va; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [2:0] expOutcome(input logic [2:0] a, input logic w);
    // {abortNr, abortRo, trap}
    case (a)
      3'd1: return w ? 3'b010 : 3'b001;
      3'd2: return w ? 3'b010 : 3'b000;
      3'd4: return 3'b001;
      3'd5: return w ? 3'b001 : 3'b000;
      3'd6: return 3'b000;
      default: return 3'b100;
    endcase
  endfunction

  task automatic testReset();
    check("R10", "rspValid after reset", 32'(rspValid), 0);
    check("R6", "status after reset", 32'(rdStatus), 0);
    check("R9", "ioPage after reset", 32'(rspIoPage), 0);
  endtask

  task automatic testAcfTable();
    for (int a = 0; a < 8; a++) begin
      for (int w = 0; w < 2; w++) begin
        logic [2:0] e;
        logic       ab;
        string      tag;
        e   = expOutcome(3'(a), w[0]);
        ab  = e[2] | e[1];
        tag = (a == 0 || a == 3 || a == 7) ? "R3" : ((a == 1 || a == 2) ? "R4" : "R5");
        loadDesc(2'd1, 1'b1, 3'd5, 16'h0100, 3'(a));
        rdMode = 2'd1; rdSpace = 1'b1; rdSeg = 3'd5;
        access(2'd1, 1'b1, 16'hA010, w[0]);
        check(tag, $sformatf("outcome acf=%0d w=%0d", a, w),
              32'({rspAbortNr, rspAbortRo, rspTrap}), 32'(e));
        check("R7", $sformatf("access acf=%0d w=%0d", a, w), 32'(rspAccess), 32'(!ab));
        check("R6", $sformatf("status acf=%0d w=%0d", a, w), 32'(rdStatus),
              ab ? 0 : 32'({e[0], w[0]}));
      end
    end
  endtask

  task automatic testSegmentSelect();
    loadDesc(2'd0, 1'b0, 3'd2, 16'h0000, 3'd6);
    loadDesc(2'd0, 1'b1, 3'd2, 16'h0000, 3'd0);
    loadDesc(2'd3, 1'b0, 3'd2, 16'h0000, 3'd4);
    loadDesc(2'd0, 1'b0, 3'd3, 16'h0000, 3'd1);
    access(2'd0, 1'b0, 16'h4000, 1'b0);
    check("R1", "kernel I seg2 allow", 32'({rspAbortNr, rspAbortRo, rspTrap}), 0);
    access(2'd0, 1'b1, 16'h5FFF, 1'b0);
    check("R1", "kernel D seg2 nr", 32'(rspAbortNr), 1);
    access(2'd3, 1'b0, 16'h4000, 1'b0);
    check("R1", "user I seg2 trap", 32'(rspTrap), 1);
    access(2'd0, 1'b0, 16'h6000, 1'b1);
    check("R1", "kernel I seg3 ro", 32'(rspAbortRo), 1);
    access(2'd1, 1'b0, 16'h4000, 1'b0);
    check("R1", "super I seg2 default nr", 32'(rspAbortNr), 1);
  endtask

  task automatic testMode2();
    loadDesc(2'd0, 1'b0, 3'd0, 16'h0000, 3'd6);
    loadDesc(2'd2, 1'b0, 3'd0, 16'h0000, 3'd6);
    access(2'd2, 1'b0, 16'h0000, 1'b0);
    check("R2", "mode2 abort", 32'(rspAbortNr), 1);
    check("R2", "mode2 no access", 32'(rspAccess), 0);
    rdMode = 2'd0; rdSpace = 1'b0; rdSeg = 3'd0;
    access(2'd0, 1'b0, 16'h0000, 1'b0);
    check("R2", "kernel survives mode2 cfg", 32'(rspAccess), 1);
    check("R2", "kernel status untouched by read", 32'(rdStatus), 0);
  endtask

  task automatic testPhysIo();
    loadDesc(2'd3, 1'b1, 3'd7, 16'h0F7F, 3'd6);
    addr22En = 1'b0;
    access(2'd3, 1'b1, 16'hE03F, 1'b0);
    check("R8", "narrow phys", 32'(rspPhys), 32'h3DFFF);
    check("R9", "narrow below io", 32'(rspIoPage), 0);
    access(2'd3, 1'b1, 16'hE040, 1'b0);
    check("R9", "narrow at io", 32'(rspIoPage), 1);
    addr22En = 1'b1;
    access(2'd3, 1'b1, 16'hE040, 1'b0);
    check("R9", "wide not io", 32'(rspIoPage), 0);
    loadDesc(2'd3, 1'b1, 3'd7, 16'hFF7F, 3'd6);
    access(2'd3, 1'b1, 16'hE03F, 1'b0);
    check("R8", "wide phys", 32'(rspPhys), 32'h3FDFFF);
    check("R9", "wide below io", 32'(rspIoPage), 0);
    access(2'd3, 1'b1, 16'hE040, 1'b0);
    check("R9", "wide at io", 32'(rspIoPage), 1);
    addr22En = 1'b0;
    access(2'd3, 1'b1, 16'hE040, 1'b0);
    check("R8", "narrow truncation", 32'(rspPhys), 32'h3E000);
    addr22En = 1'b1;
    loadDesc(2'd3, 1'b1, 3'd7, 16'hFF80, 3'd0);
    access(2'd3, 1'b1, 16'hE000, 1'b0);
    check("R9", "aborted no io", 32'(rspIoPage), 0);
  endtask

  task automatic testStatusSticky();
    loadDesc(2'd1, 1'b0, 3'd4, 16'h0000, 3'd5);
    rdMode = 2'd1; rdSpace = 1'b0; rdSeg = 3'd4;
    access(2'd1, 1'b0, 16'h8000, 1'b1);
    check("R6", "trap write sets both", 32'(rdStatus), 3);
    access(2'd1, 1'b0, 16'h8000, 1'b0);
    check("R6", "read keeps sticky", 32'(rdStatus), 3);
    loadDesc(2'd1, 1'b0, 3'd4, 16'h0000, 3'd2);
    check("R6", "cfg clears", 32'(rdStatus), 0);
    access(2'd1, 1'b0, 16'h8000, 1'b1);
    check("R7", "ro abort no status", 32'(rdStatus), 0);
  endtask

  task automatic testLatency();
    @(negedge clk);
    reqValid = 1'b1; reqMode = 2'd0; reqSpace = 1'b0; reqAddr = 16'h0000; reqWrite = 1'b0;
    check("R10", "no result same cycle", 32'(rspValid), 0);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "result next cycle", 32'(rspValid), 1);
    @(negedge clk);
    check("R10", "single-cycle pulse", 32'(rspValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAcfTable();
    testSegmentSelect();
    testMode2();
    testPhysIo();
    testStatusSticky();
    testLatency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule